// File: doc/BRIEF.md
# Clocked Serial Absolute-Encoder Reader

This block reads an absolute position encoder over a two-wire clocked serial link. On request, or continuously when free-run is enabled, it sends the encoder a burst of clock pulses on a line that rests high. The first falling edge of a burst makes the encoder freeze its position. Each rising edge after that makes the encoder put out the next bit, most significant bit first. The block samples the returning data line once per pulse and builds a 24-bit word from the bits. It then presents the word on a parallel output together with a one-cycle strobe.

After the last pulse, the clock line is held high for a programmable recovery gap. An encoder that receives a new burst before it has rested for this long sends its old value again, so the gap is required for a fresh reading. The clock rate is set by a half-period divider in system clock cycles. A divider of 50 at a 200 MHz system clock gives a 2 MHz encoder clock.

The returning data passes through a two-stage synchronizer. It is sampled in the last system cycle of each high phase, which is half an encoder clock period after the rising edge. This delay absorbs the round trip through cable and line drivers.

The controller has four states:
- `ST_IDLE`: the line is high and busy is low. A start pulse or free-run moves it to `ST_LOW`.
- `ST_LOW`: the low half of a pulse. It moves to `ST_HIGH` when the phase timer expires.
- `ST_HIGH`: the high half of a pulse, with the sample taken as the phase ends. When the phase timer expires it returns to `ST_LOW`, or moves to `ST_GAP` if that sample was the 24th bit.
- `ST_GAP`: the recovery gap. It moves to `ST_IDLE` when the gap timer expires.

Top module: `enc_reader`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `enc_clk` is 1, `busy` is 0, `pos_valid` is 0 and `position` is 0.
- R2: When `start` is 1 on a clock edge while `busy` is 0, both of the following happen in the next cycle: `enc_clk` goes to 0 and `busy` goes to 1. `enc_clk` is never 0 while `busy` is 0.
- R3: Every read drives exactly 24 low pulses on `enc_clk`.
- R4: Every low phase and every high phase between pulses lasts `half_div` system cycles. Values of `half_div` below 4 act as 4.
- R5: The first bit sampled in a burst lands in `position[23]` and the last lands in `position[0]`.
- R6: `pos_valid` is high for exactly one cycle, in the cycle after the 24th sample. `position` changes only in a cycle where `pos_valid` is 1.
- R7: `busy` and `enc_clk` both stay at 1 for `gap_cycles` cycles, counted from the `pos_valid` cycle. A `gap_cycles` of 0 selects the default of 4000 cycles, which is 20 µs at 200 MHz.
- R8: A `start` pulse that arrives while `busy` is 1 is ignored. No extra pulse, word or burst results from it.
- R9: With `free_run` at 1, a new burst begins after exactly one idle cycle (with `busy` at 0) after each recovery gap, with no `start` needed.
- R10: `enc_data` passes through two synchronizer flops and is sampled at the end of each high phase. A bit that reaches the pin as late as `half_div`−3 cycles after a rising edge is still captured correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request for a single read |
| free_run | input | 1 | Repeat reads automatically while held at 1 |
| half_div | input | 12 | Half-period of the encoder clock, in system cycles |
| gap_cycles | input | 16 | Recovery gap length in system cycles; 0 selects the default |
| enc_clk | output | 1 | Clock line to the encoder, idle high |
| enc_data | input | 1 | Serial data from the encoder |
| position | output | 24 | Last position word assembled |
| pos_valid | output | 1 | One-cycle strobe marking a new `position` |
| busy | output | 1 | High from burst start until the recovery gap ends |

## Verification
`enc_clk` falls and `busy` rises one cycle after `start` is sampled, and the driver checks this at the next falling edge of the system clock. The 24th sample is taken on the edge that ends the last high phase. `pos_valid` and the new `position` appear in the cycle after that edge. `busy` falls exactly `gap_cycles` cycles after `pos_valid` appears.

The scoreboard monitor samples on falling edges and counts phase lengths, pulses and gap cycles relative to these events. It therefore compares each result against the cycle in which it is due, not against a timeout. A behavioural encoder model drives each bit a programmable number of cycles after a rising edge, to exercise the timing limit in R10.

// File: rtl/enc_rd_pkg.sv
package enc_rd_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOW  = 2'd1,
        ST_HIGH = 2'd2,
        ST_GAP  = 2'd3
    } rd_state_t;

endpackage

// File: rtl/enc_sync.sv
module enc_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);

    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= {STAGES{RST_VAL}};
                else        chain_q <= d;
            end
        end else begin : g_multi
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= {STAGES{RST_VAL}};
                else        chain_q <= {chain_q[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain_q[STAGES-1];

endmodule

// File: rtl/enc_interval_timer.sv
module enc_interval_timer #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic [W-1:0] limit,
    output logic         tick
);

    logic [W-1:0] cnt_q;

    // limit is guaranteed non-zero by the caller
    assign tick = run && (cnt_q == limit - W'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            cnt_q <= '0;
        else if (!run || tick) cnt_q <= '0;
        else                   cnt_q <= cnt_q + W'(1);
    end

endmodule

// File: rtl/enc_shifter.sv
module enc_shifter #(
    parameter int BITS = 24
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clear,
    input  logic            shift_en,
    input  logic            bit_in,
    output logic            last,
    output logic [BITS-1:0] word,
    output logic            word_vld
);

    localparam int CW = $clog2(BITS);

    logic [BITS-1:0] sr_q;
    logic [BITS-1:0] word_q;
    logic [CW-1:0]   cnt_q;
    logic            vld_q;

    assign last     = (cnt_q == CW'(BITS - 1));
    assign word     = word_q;
    assign word_vld = vld_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr_q   <= '0;
            word_q <= '0;
            cnt_q  <= '0;
            vld_q  <= 1'b0;
        end else begin
            vld_q <= 1'b0;
            if (clear) begin
                sr_q  <= '0;
                cnt_q <= '0;
            end else if (shift_en) begin
                sr_q  <= {sr_q[BITS-2:0], bit_in};
                cnt_q <= last ? '0 : cnt_q + CW'(1);
                if (last) begin
                    word_q <= {sr_q[BITS-2:0], bit_in};
                    vld_q  <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/enc_reader.sv
module enc_reader
    import enc_rd_pkg::*;
#(
    parameter int WORD_BITS   = 24,
    parameter int DIV_W       = 12,
    parameter int GAP_W       = 16,
    parameter int GAP_DEFAULT = 4000,
    parameter int MIN_HALF    = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic                 free_run,
    input  logic [DIV_W-1:0]     half_div,
    input  logic [GAP_W-1:0]     gap_cycles,
    output logic                 enc_clk,
    input  logic                 enc_data,
    output logic [WORD_BITS-1:0] position,
    output logic                 pos_valid,
    output logic                 busy
);

    localparam logic [DIV_W-1:0] HALF_FLOOR = DIV_W'(MIN_HALF);
    localparam logic [GAP_W-1:0] GAP_DFLT   = GAP_W'(GAP_DEFAULT);

    rd_state_t state_q, state_d;

    logic [DIV_W-1:0] half_eff;
    logic [GAP_W-1:0] gap_eff;
    logic             phase_run, phase_tick;
    logic             gap_run, gap_tick;
    logic             shift_en, burst_clr, last_bit, din_s;
    logic             launch;

    assign half_eff = (half_div < HALF_FLOOR) ? HALF_FLOOR : half_div;
    assign gap_eff  = (gap_cycles == '0) ? GAP_DFLT : gap_cycles;
    assign launch   = start || free_run;

    enc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (enc_data),
        .q     (din_s)
    );

    enc_interval_timer #(.W(DIV_W)) u_phase (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (phase_run),
        .limit (half_eff),
        .tick  (phase_tick)
    );

    enc_interval_timer #(.W(GAP_W)) u_gap (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (gap_run),
        .limit (gap_eff),
        .tick  (gap_tick)
    );

    enc_shifter #(.BITS(WORD_BITS)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (burst_clr),
        .shift_en (shift_en),
        .bit_in   (din_s),
        .last     (last_bit),
        .word     (position),
        .word_vld (pos_valid)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (launch)     state_d = ST_LOW;
            ST_LOW:  if (phase_tick) state_d = ST_HIGH;
            ST_HIGH: if (phase_tick) state_d = last_bit ? ST_GAP : ST_LOW;
            ST_GAP:  if (gap_tick)   state_d = ST_IDLE;
            default:                 state_d = ST_IDLE;
        endcase
    end

    // outputs and control strobes
    always_comb begin
        enc_clk   = 1'b1;
        busy      = 1'b1;
        phase_run = 1'b0;
        gap_run   = 1'b0;
        shift_en  = 1'b0;
        burst_clr = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                busy      = 1'b0;
                burst_clr = launch;
            end
            ST_LOW: begin
                enc_clk   = 1'b0;
                phase_run = 1'b1;
            end
            ST_HIGH: begin
                phase_run = 1'b1;
                shift_en  = phase_tick;
            end
            ST_GAP: begin
                gap_run = 1'b1;
            end
            default: busy = 1'b0;
        endcase
    end

endmodule

// File: rtl/enc_reader_chk.sv
module enc_reader_chk #(
    parameter int WORD_BITS = 24
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 start,
    input logic                 free_run,
    input logic                 enc_clk,
    input logic [WORD_BITS-1:0] position,
    input logic                 pos_valid,
    input logic                 busy
);

    // R1
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (enc_clk && !busy && !pos_valid));

    // R2
    start_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> (busy && !enc_clk));

    // R2
    low_needs_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enc_clk |-> busy);

    // R6
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pos_valid |=> !pos_valid);

    // R6
    hold_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pos_valid |-> $stable(position));

    // R7
    gap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pos_valid |-> (busy && enc_clk));

    // R8
    idle_stay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start && !free_run) |=> !busy);

    // R9
    freerun_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy) && free_run) |=> busy);

endmodule

bind enc_reader enc_reader_chk #(.WORD_BITS(WORD_BITS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .free_run  (free_run),
    .enc_clk   (enc_clk),
    .position  (position),
    .pos_valid (pos_valid),
    .busy      (busy)
);

// File: tb/tb_enc_reader.sv
`timescale 1ns/1ps
module tb_enc_reader;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        free_run = 1'b0;
    logic [11:0] half_div = 12'd6;
    logic [15:0] gap_cycles = 16'd20;
    logic        enc_clk;
    logic        enc_data = 1'b0;
    logic [23:0] position;
    logic        pos_valid;
    logic        busy;

    always #2.5 clk = ~clk;

    enc_reader dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .free_run   (free_run),
        .half_div   (half_div),
        .gap_cycles (gap_cycles),
        .enc_clk    (enc_clk),
        .enc_data   (enc_data),
        .position   (position),
        .pos_valid  (pos_valid),
        .busy       (busy)
    );

    int tests = 0;
    int fails = 0;
    logic [23:0] exp_q[$];
    int exp_h = 6;
    int exp_g = 20;
    int done_cnt = 0;
    bit fr_mode = 0;

    localparam logic [23:0] STEP = 24'h010203;

    task automatic check(input bit ok, input string tag,
                         input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // ---------------- encoder model ----------------
    logic [23:0] enc_pos = 24'h0;
    logic [23:0] latched = 24'h0;
    int rises = 24;
    int data_lag = 0;
    logic m_prev = 1'b1;
    bit pend_v = 0;
    logic pend_b = 1'b0;
    int pend_cd = 0;

    always @(negedge clk) begin
        if (m_prev && !enc_clk && rises == 24) begin
            latched = enc_pos;
            enc_pos = enc_pos + STEP;
            rises = 0;
        end
        if (!m_prev && enc_clk && rises < 24) begin
            pend_b  = latched[23 - rises];
            pend_v  = 1;
            pend_cd = data_lag;
            rises++;
        end
        if (pend_v) begin
            if (pend_cd == 0) begin
                enc_data = pend_b;
                pend_v = 0;
            end else pend_cd--;
        end
        m_prev = enc_clk;
    end

    // ---------------- monitor / scoreboard ----------------
    int lo_len = 0, hi_len = 0, falls = 0, gap_cnt = 0, idle_len = 0, fr_valids = 0;
    bit ph_bad = 0, gap_meas = 0, gap_bad = 0;
    logic p_clk = 1'b1, p_busy = 1'b0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (!fr_mode) fr_valids = 0;
            if (busy && !p_busy) begin
                // R9: exactly one idle cycle between free-run bursts
                if (fr_mode && fr_valids > 0)
                    check(idle_len == 1, "R9 idle cycles between bursts", idle_len, 1);
                idle_len = 0;
                falls = 0; ph_bad = 0; lo_len = 0; hi_len = 0;
            end
            if (!busy) idle_len++;
            if (busy && !gap_meas && !pos_valid) begin
                if (!enc_clk) begin
                    if (p_clk) begin
                        if (falls > 0 && hi_len != exp_h) ph_bad = 1;
                        falls++;
                        lo_len = 0;
                    end
                    lo_len++;
                end else begin
                    if (!p_clk) begin
                        if (lo_len != exp_h) ph_bad = 1;
                        hi_len = 0;
                    end
                    hi_len++;
                end
            end
            if (pos_valid) begin
                if (exp_q.size() == 0) begin
                    check(0, "R8 unexpected word", position, 0);
                end else begin
                    logic [23:0] e;
                    e = exp_q.pop_front();
                    check(position == e, "R5 position word", position, e);
                end
                check(falls == 24, "R3 pulse count", falls, 24);
                check(!ph_bad, "R4 phase length", ph_bad, 0);
                if (fr_mode) fr_valids++;
                gap_meas = 1; gap_cnt = 0; gap_bad = 0;
            end
            if (gap_meas) begin
                if (busy) begin
                    gap_cnt++;
                    if (!enc_clk) gap_bad = 1;
                end else begin
                    check(gap_cnt == exp_g && !gap_bad, "R7 gap length", gap_cnt, exp_g);
                    gap_meas = 0;
                    done_cnt++;
                end
            end
        end
        p_clk = enc_clk;
        p_busy = busy;
    end

    // ---------------- driver ----------------
    task automatic read_once(input logic [23:0] pos, input int h, input int g,
                             input int lag, input int extra_start);
        int target;
        target   = done_cnt + 1;
        half_div = 12'(h);
        gap_cycles = 16'(g);
        exp_h    = (h < 4) ? 4 : h;
        exp_g    = (g == 0) ? 4000 : g;
        data_lag = lag;
        enc_pos  = pos;
        exp_q.push_back(pos);
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        // R2: launch one cycle after start is sampled
        check(enc_clk == 1'b0 && busy == 1'b1, "R2 launch", {enc_clk, busy}, 2'b01);
        if (extra_start > 0) begin
            repeat (extra_start) @(negedge clk);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        wait (done_cnt >= target);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check(enc_clk == 1'b1 && busy == 1'b0 && pos_valid == 1'b0,
              "R1 reset outputs", {enc_clk, busy, pos_valid}, 3'b100);
        check(position == 24'h0, "R1 reset position", position, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(enc_clk == 1'b1 && busy == 1'b0 && position == 24'h0,
              "R1 after release", {enc_clk, busy}, 2'b10);

        read_once(24'hA5C31E, 6, 20, 0, 0);
        read_once(24'h800001, 2, 10, 0, 0);   // R4 clamp to 4
        read_once(24'h5AF00F, 5, 0, 0, 0);    // R7 default gap
        read_once(24'hFFFFFE, 6, 15, 0, 100); // R8 start while busy
        repeat (40) @(negedge clk);
        check(busy == 1'b0 && exp_q.size() == 0, "R8 no extra burst", busy, 0);
        read_once(24'h13579B, 8, 12, 5, 0);   // R10 late data
        read_once(24'h000000, 4, 8, 1, 0);

        // R9: free-run, three reads without start
        begin
            int target;
            half_div = 12'd4; gap_cycles = 16'd30;
            exp_h = 4; exp_g = 30; data_lag = 0;
            enc_pos = 24'h3C3C3C;
            exp_q.push_back(24'h3C3C3C);
            exp_q.push_back(24'h3C3C3C + STEP);
            exp_q.push_back(24'h3C3C3C + STEP + STEP);
            target = done_cnt + 3;
            fr_mode = 1;
            @(negedge clk);
            free_run = 1'b1;
            wait (exp_q.size() == 0);
            @(negedge clk);
            free_run = 1'b0;
            wait (done_cnt >= target);
            repeat (20) @(negedge clk);
            fr_mode = 0;
            check(busy == 1'b0, "R9 stops when disabled", busy, 0);
        end

        check(exp_q.size() == 0, "R5 all words seen", exp_q.size(), 0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule